// File: doc/BRIEF.md
# Single-Cycle Byte Processor

This block is a compact processor core whose instructions, data words and addresses are all one byte wide. It holds four general registers, a zero flag and a negative flag, a program counter, and two separate 256-byte memories: one for the program and one for data. Each instruction is fully handled within a single clock period. The instruction is fetched, decoded, the register file is read, the ALU or data memory acts, and the result, the flags and the program counter are committed together on the falling clock edge.

The program memory and the data memory are internal arrays. Whatever environment hosts the core fills them while reset is held. The only outputs are a registered debug view of the program counter, the four registers and the two flags. Software running on the core therefore shows its effect there. A stored byte is observed by loading it back into a register.

Top module: `byte_cpu`

## Requirements
- R1: A falling edge with `rst` high sets the PC to 0x80, clears k0..k3 and clears both flags. No data memory write happens on that edge.
- R2: After any instruction that is not a taken branch, the PC equals the previous PC plus 1, wrapping modulo 256.
- R3: Low nibble 0000 loads data memory at address k[bits 5:4] into k[bits 7:6]. Low nibble 0010 writes k[bits 7:6] to data memory at address k[bits 5:4]. Neither changes Z or N.
- R4: Low nibbles 0100, 0110 and 1000 replace k[bits 7:6] with its sum with k[bits 5:4], its difference k[7:6] minus k[5:4], and the bitwise NAND of the two. All three results are modulo 256.
- R5: After add, sub, nand, the immediate OR and shift, Z is 1 exactly when the written byte is zero, and N equals bit 7 of the written byte.
- R6: Low three bits 111 OR the zero-extended value of bits 7:3 into k1. k0, k2 and k3 are left unchanged, whatever bits 7:3 contain.
- R7: Low three bits 011 shift k[bits 4:3] by the amount in bits 6:5. The shift is to the left when bit 7 is 1 and a logical shift to the right when bit 7 is 0.
- R8: Low nibbles 0101 (taken when Z=1), 1001 (taken when Z=0) and 1101 (taken when N=0) are branches. A taken branch sets the PC to PC + 1 + the sign-extended two's-complement value of bits 7:4, modulo 256. A branch that is not taken behaves as R2.
- R9: Low nibbles 0001, 1010, 1100 and 1110 change no register, no flag and no memory location. They only advance the PC by 1.
- R10: State and debug outputs change only at falling clock edges. They hold steady through the high phase of the clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state commits on its falling edge |
| rst | input | 1 | Synchronous active-high reset, sampled at the falling edge |
| dbg_pc | output | 8 | Current program counter |
| dbg_regs | output | 32 | Registers k0..k3, with k0 in bits 7:0 and k3 in bits 31:24 |
| dbg_z | output | 1 | Zero flag |
| dbg_n | output | 1 | Negative flag |

## Verification
Several events can land on the same falling edge. A register can be both the source and the destination of one instruction, as in add or nand of a register with itself, or a load through the register it overwrites. A taken branch can wrap the PC across 0xFF/0x00 while its flag was written by the instruction just before it. A store followed immediately by a load of the same address needs the data memory write and read to meet across a single edge. Long runs of random program bytes with random data memory produce all of these cases, and each cycle is judged against a behavioural reference model. A hand-written program then checks flag-driven branching and a store/load round trip against values worked out by hand.

// File: rtl/byte_cpu_pkg.sv
package byte_cpu_pkg;

  localparam int DATA_W  = 8;
  localparam int RIDX_W  = 2;
  localparam int SHAMT_W = 2;

  typedef enum logic [3:0] {
    OP_NOP,
    OP_LOAD,
    OP_STORE,
    OP_ADD,
    OP_SUB,
    OP_NAND,
    OP_ORI,
    OP_SHIFT,
    OP_BZ,
    OP_BNZ,
    OP_BPZ
  } op_e;

  typedef enum logic [2:0] {
    ALU_ADD,
    ALU_SUB,
    ALU_OR,
    ALU_NAND,
    ALU_SHIFT
  } alu_e;

  typedef struct packed {
    op_e                op;
    alu_e               alu;
    logic [RIDX_W-1:0]  ra;
    logic [RIDX_W-1:0]  rb;
    logic               reg_we;
    logic               flag_we;
    logic               mem_we;
    logic               wb_mem;
    logic               src_imm;
    logic               shl;
    logic [SHAMT_W-1:0] shamt;
    logic [DATA_W-1:0]  imm;
  } ctl_t;

endpackage

// File: rtl/byte_cpu_decode.sv
module byte_cpu_decode
  import byte_cpu_pkg::*;
(
  input  logic [DATA_W-1:0] instr,
  output ctl_t              ctl
);

  localparam logic [RIDX_W-1:0] ORI_DEST = RIDX_W'(1);

  always_comb begin
    ctl       = '0;
    ctl.op    = OP_NOP;
    ctl.alu   = ALU_ADD;
    ctl.ra    = instr[7:6];
    ctl.rb    = instr[5:4];
    if (instr[2:0] == 3'b111) begin
      ctl.op      = OP_ORI;
      ctl.ra      = ORI_DEST;
      ctl.alu     = ALU_OR;
      ctl.src_imm = 1'b1;
      ctl.imm     = DATA_W'(instr[7:3]);
      ctl.reg_we  = 1'b1;
      ctl.flag_we = 1'b1;
    end else if (instr[2:0] == 3'b011) begin
      ctl.op      = OP_SHIFT;
      ctl.ra      = instr[4:3];
      ctl.alu     = ALU_SHIFT;
      ctl.shl     = instr[7];
      ctl.shamt   = instr[6:5];
      ctl.reg_we  = 1'b1;
      ctl.flag_we = 1'b1;
    end else begin
      ctl.imm = {{(DATA_W-4){instr[7]}}, instr[7:4]};
      unique case (instr[3:0])
        4'b0000: begin
          ctl.op     = OP_LOAD;
          ctl.reg_we = 1'b1;
          ctl.wb_mem = 1'b1;
        end
        4'b0010: begin
          ctl.op     = OP_STORE;
          ctl.mem_we = 1'b1;
        end
        4'b0100: begin
          ctl.op      = OP_ADD;
          ctl.alu     = ALU_ADD;
          ctl.reg_we  = 1'b1;
          ctl.flag_we = 1'b1;
        end
        4'b0110: begin
          ctl.op      = OP_SUB;
          ctl.alu     = ALU_SUB;
          ctl.reg_we  = 1'b1;
          ctl.flag_we = 1'b1;
        end
        4'b1000: begin
          ctl.op      = OP_NAND;
          ctl.alu     = ALU_NAND;
          ctl.reg_we  = 1'b1;
          ctl.flag_we = 1'b1;
        end
        4'b0101: ctl.op = OP_BZ;
        4'b1001: ctl.op = OP_BNZ;
        4'b1101: ctl.op = OP_BPZ;
        default: ctl.op = OP_NOP;
      endcase
    end
  end

endmodule

// File: rtl/byte_cpu_alu.sv
module byte_cpu_alu
  import byte_cpu_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic [DW-1:0]      opa,
  input  logic [DW-1:0]      opb,
  input  alu_e               sel,
  input  logic               shl,
  input  logic [SHAMT_W-1:0] shamt,
  output logic [DW-1:0]      res,
  output logic               zero,
  output logic               neg
);

  always_comb begin
    unique case (sel)
      ALU_ADD:   res = opa + opb;
      ALU_SUB:   res = opa - opb;
      ALU_OR:    res = opa | opb;
      ALU_NAND:  res = ~(opa & opb);
      ALU_SHIFT: res = shl ? (opa << shamt) : (opa >> shamt);
      default:   res = opa;
    endcase
  end

  assign zero = (res == '0);
  assign neg  = res[DW-1];

endmodule

// File: rtl/byte_cpu_regfile.sv
module byte_cpu_regfile #(
  parameter int NREG = 4,
  parameter int DW   = 8,
  localparam int IW  = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [IW-1:0]    wa,
  input  logic [DW-1:0]    wd,
  input  logic [IW-1:0]    ra1,
  input  logic [IW-1:0]    ra2,
  output logic [DW-1:0]    rd1,
  output logic [DW-1:0]    rd2,
  output logic [NREG*DW-1:0] dbg
);

  logic [DW-1:0] rf_q [NREG];

  always_ff @(negedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) rf_q[i] <= '0;
    end else if (we) begin
      rf_q[wa] <= wd;
    end
  end

  assign rd1 = rf_q[ra1];
  assign rd2 = rf_q[ra2];

  for (genvar g = 0; g < NREG; g++) begin : g_dbg
    assign dbg[g*DW +: DW] = rf_q[g];
  end

endmodule

// File: rtl/byte_cpu_mem.sv
module byte_cpu_mem #(
  parameter int AW = 8,
  parameter int DW = 8,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(negedge clk) begin
    if (we) mem_q[addr] <= wdata;
  end

  assign rdata = mem_q[addr];

endmodule

// File: rtl/byte_cpu.sv
module byte_cpu
  import byte_cpu_pkg::*;
#(
  parameter int              AW     = 8,
  parameter int              NREG   = 4,
  parameter logic [AW-1:0]   RST_PC = AW'('h80),
  localparam int             DW     = DATA_W
) (
  input  logic               clk,
  input  logic               rst,
  output logic [AW-1:0]      dbg_pc,
  output logic [NREG*DW-1:0] dbg_regs,
  output logic               dbg_z,
  output logic               dbg_n
);

  logic [AW-1:0] pc_q;
  logic          z_q;
  logic          n_q;
  logic [DW-1:0] instr_w;
  ctl_t          ctl;
  logic [DW-1:0] rd1;
  logic [DW-1:0] rd2;
  logic [DW-1:0] alu_b;
  logic [DW-1:0] alu_res;
  logic          alu_z;
  logic          alu_n;
  logic [DW-1:0] dmem_rd;
  logic [DW-1:0] wb_data;
  logic          take;
  logic [AW-1:0] pc_next;

  byte_cpu_mem #(.AW(AW), .DW(DW)) u_imem (
    .clk   (clk),
    .we    (1'b0),
    .addr  (pc_q),
    .wdata ('0),
    .rdata (instr_w)
  );

  byte_cpu_decode u_dec (
    .instr (instr_w),
    .ctl   (ctl)
  );

  byte_cpu_regfile #(.NREG(NREG), .DW(DW)) u_rf (
    .clk (clk),
    .rst (rst),
    .we  (ctl.reg_we & ~rst),
    .wa  (ctl.ra),
    .wd  (wb_data),
    .ra1 (ctl.ra),
    .ra2 (ctl.rb),
    .rd1 (rd1),
    .rd2 (rd2),
    .dbg (dbg_regs)
  );

  assign alu_b = ctl.src_imm ? ctl.imm : rd2;

  byte_cpu_alu #(.DW(DW)) u_alu (
    .opa   (rd1),
    .opb   (alu_b),
    .sel   (ctl.alu),
    .shl   (ctl.shl),
    .shamt (ctl.shamt),
    .res   (alu_res),
    .zero  (alu_z),
    .neg   (alu_n)
  );

  byte_cpu_mem #(.AW(AW), .DW(DW)) u_dmem (
    .clk   (clk),
    .we    (ctl.mem_we & ~rst),
    .addr  (rd2[AW-1:0]),
    .wdata (rd1),
    .rdata (dmem_rd)
  );

  assign wb_data = ctl.wb_mem ? dmem_rd : alu_res;

  always_comb begin
    unique case (ctl.op)
      OP_BZ:   take = z_q;
      OP_BNZ:  take = ~z_q;
      OP_BPZ:  take = ~n_q;
      default: take = 1'b0;
    endcase
  end

  assign pc_next = pc_q + AW'(1) + (take ? AW'(signed'(ctl.imm)) : '0);

  always_ff @(negedge clk) begin
    if (rst) begin
      pc_q <= RST_PC;
      z_q  <= 1'b0;
      n_q  <= 1'b0;
    end else begin
      pc_q <= pc_next;
      if (ctl.flag_we) begin
        z_q <= alu_z;
        n_q <= alu_n;
      end
    end
  end

  assign dbg_pc = pc_q;
  assign dbg_z  = z_q;
  assign dbg_n  = n_q;

endmodule

// File: rtl/byte_cpu_chk.sv
module byte_cpu_chk #(
  parameter logic [7:0] RST_PC = 8'h80
) (
  input logic        clk,
  input logic        rst,
  input logic [7:0]  instr,
  input logic [7:0]  pc,
  input logic [31:0] regs,
  input logic        z,
  input logic        n
);

  logic is_branch;
  logic is_ldst;
  logic is_ori;
  assign is_branch = (instr[3:0] == 4'b0101) || (instr[3:0] == 4'b1001) ||
                     (instr[3:0] == 4'b1101);
  assign is_ldst   = (instr[3:0] == 4'b0000) || (instr[3:0] == 4'b0010);
  assign is_ori    = (instr[2:0] == 3'b111);

  a_r1_reset_state: assert property (@(negedge clk)
    $past(rst) |-> (pc == RST_PC && regs == 32'h0 && !z && !n));

  a_r2_pc_step: assert property (@(negedge clk) disable iff (rst)
    (!is_branch) |=> (pc == 8'($past(pc) + 8'd1)));

  a_r3_flags_hold: assert property (@(negedge clk) disable iff (rst)
    is_ldst |=> ($stable(z) && $stable(n)));

  a_r6_ori_others: assert property (@(negedge clk) disable iff (rst)
    is_ori |=> ($stable(regs[7:0]) && $stable(regs[31:16])));

  a_r5_ori_flags: assert property (@(negedge clk) disable iff (rst)
    is_ori |=> (z == (regs[15:8] == 8'h0) && n == regs[15]));

  a_r8_bz_taken: assert property (@(negedge clk) disable iff (rst)
    (instr[3:0] == 4'b0101 && z) |=>
      (pc == 8'($past(pc) + 8'd1 + {{4{$past(instr[7])}}, $past(instr[7:4])})));

endmodule

bind byte_cpu byte_cpu_chk u_chk (
  .clk   (clk),
  .rst   (rst),
  .instr (instr_w),
  .pc    (pc_q),
  .regs  (dbg_regs),
  .z     (z_q),
  .n     (n_q)
);

// File: tb/tb_byte_cpu.sv
module tb_byte_cpu;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  dbg_pc;
  logic [31:0] dbg_regs;
  logic        dbg_z;
  logic        dbg_n;

  int n_checks = 0;
  int n_fails  = 0;

  always #4 clk = ~clk;

  byte_cpu dut (
    .clk      (clk),
    .rst      (rst),
    .dbg_pc   (dbg_pc),
    .dbg_regs (dbg_regs),
    .dbg_z    (dbg_z),
    .dbg_n    (dbg_n)
  );

  logic [7:0] m_imem [256];
  logic [7:0] m_dmem [256];
  logic [7:0] m_r    [4];
  logic [7:0] m_pc;
  logic       m_z;
  logic       m_n;
  string      m_tag;
  bit         m_flagop;
  bit         m_brop;

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic model_step();
    logic [7:0] ins;
    logic [7:0] res;
    logic [7:0] nxt;
    logic [1:0] a;
    logic [1:0] b;
    int         d;
    ins = m_imem[m_pc];
    a = ins[7:6];
    b = ins[5:4];
    nxt = m_pc + 8'd1;
    m_flagop = 0;
    m_brop = 0;
    if (ins[2:0] == 3'b111) begin
      m_tag = "R6";
      res = m_r[1] | {3'b000, ins[7:3]};
      m_r[1] = res;
      m_flagop = 1;
    end else if (ins[2:0] == 3'b011) begin
      m_tag = "R7";
      d = int'(ins[4:3]);
      if (ins[7]) res = m_r[d] << ins[6:5];
      else        res = m_r[d] >> ins[6:5];
      m_r[d] = res;
      m_flagop = 1;
    end else begin
      res = 8'h00;
      case (ins[3:0])
        4'h0: begin m_tag = "R3"; m_r[a] = m_dmem[m_r[b]]; end
        4'h2: begin m_tag = "R3"; m_dmem[m_r[b]] = m_r[a]; end
        4'h4: begin m_tag = "R4"; res = m_r[a] + m_r[b]; m_r[a] = res; m_flagop = 1; end
        4'h6: begin m_tag = "R4"; res = m_r[a] - m_r[b]; m_r[a] = res; m_flagop = 1; end
        4'h8: begin m_tag = "R4"; res = ~(m_r[a] & m_r[b]); m_r[a] = res; m_flagop = 1; end
        4'h5: begin m_tag = "R8"; m_brop = 1; if (m_z)  nxt = m_pc + 8'd1 + {{4{ins[7]}}, ins[7:4]}; end
        4'h9: begin m_tag = "R8"; m_brop = 1; if (!m_z) nxt = m_pc + 8'd1 + {{4{ins[7]}}, ins[7:4]}; end
        4'hD: begin m_tag = "R8"; m_brop = 1; if (!m_n) nxt = m_pc + 8'd1 + {{4{ins[7]}}, ins[7:4]}; end
        default: m_tag = "R9";
      endcase
    end
    if (m_flagop) begin
      m_z = (res == 8'h00);
      m_n = res[7];
    end
    m_pc = nxt;
  endtask

  task automatic compare_model();
    chk(m_brop ? "R8" : "R2", "pc", {24'h0, dbg_pc}, {24'h0, m_pc});
    chk(m_tag, "regs", dbg_regs, {m_r[3], m_r[2], m_r[1], m_r[0]});
    chk(m_flagop ? "R5" : m_tag, "flags", {30'h0, dbg_z, dbg_n}, {30'h0, m_z, m_n});
  endtask

  task automatic load_mems(input bit directed);
    for (int i = 0; i < 256; i++) begin
      m_imem[i] = directed ? 8'h01 : 8'($urandom_range(0, 255));
      m_dmem[i] = 8'($urandom_range(0, 255));
    end
    if (directed) begin
      m_imem[8'h80] = 8'h2F;
      m_imem[8'h81] = 8'h14;
      m_imem[8'h82] = 8'h16;
      m_imem[8'h83] = 8'h25;
      m_imem[8'h84] = 8'hFF;
      m_imem[8'h85] = 8'hFF;
      m_imem[8'h86] = 8'h42;
      m_imem[8'h87] = 8'h80;
      m_imem[8'h88] = 8'hD3;
      m_imem[8'h89] = 8'hA8;
      m_imem[8'h8A] = 8'h0D;
      m_imem[8'h8B] = 8'h01;
      m_imem[8'h8C] = 8'hF9;
    end
    for (int i = 0; i < 256; i++) begin
      dut.u_imem.mem_q[i] = m_imem[i];
      dut.u_dmem.mem_q[i] = m_dmem[i];
    end
  endtask

  task automatic run_round(input int ncyc, input bit directed);
    logic [41:0] snap;
    rst = 1'b1;
    @(negedge clk);
    #1;
    load_mems(directed);
    @(negedge clk);
    @(negedge clk);
    @(posedge clk);
    #1;
    chk("R1", "reset pc", {24'h0, dbg_pc}, 32'h80);
    chk("R1", "reset regs", dbg_regs, 32'h0);
    chk("R1", "reset flags", {30'h0, dbg_z, dbg_n}, 32'h0);
    m_pc = 8'h80;
    m_z = 0;
    m_n = 0;
    for (int i = 0; i < 4; i++) m_r[i] = 8'h00;
    rst = 1'b0;
    model_step();
    for (int c = 0; c < ncyc; c++) begin
      @(posedge clk);
      #1;
      compare_model();
      snap = {dbg_pc, dbg_regs, dbg_z, dbg_n};
      #2;
      chk("R10", "high-phase stability", 32'(snap != {dbg_pc, dbg_regs, dbg_z, dbg_n}), 32'h0);
      model_step();
    end
  endtask

  initial begin
    #(8 * 150000);
    n_fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0017));
    run_round(40, 1'b1);
    // Directed program, expected by hand: R8 taken bz skips two ori, R3 store/load round trip,
    // R7 left shift of 5 by 2 gives 0x14, R4 nand gives 0xEB, R9 no-op, final bnz loop at 0x8C.
    @(posedge clk);
    #1;
    chk("R8", "directed pc", {24'h0, dbg_pc}, 32'h8C);
    chk("R3", "directed k2 after load/shift/nand", {24'h0, dbg_regs[23:16]}, 32'hEB);
    chk("R6", "directed k1", {24'h0, dbg_regs[15:8]}, 32'h05);
    chk("R4", "directed k0 after sub", {24'h0, dbg_regs[7:0]}, 32'h00);
    chk("R9", "directed k3 untouched", {24'h0, dbg_regs[31:24]}, 32'h00);
    chk("R5", "directed flags Z N", {30'h0, dbg_z, dbg_n}, 32'h1);
    for (int r = 0; r < 6; r++) run_round(3000, 1'b0);
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

endmodule